// File: doc/BRIEF.md
# Booth-Recoded Carry-Save Mantissa Multiplier

This block multiplies two unsigned 24-bit mantissas, each with its hidden leading one already in place, and returns the full 48-bit product. It is the integer core of a floating-point fused multiply-add pipeline. Exponents, signs, rounding and special values are handled elsewhere.

The multiplier operand is recoded into radix-4 signed digits from overlapping bit triples. Each digit selects 0, ±A or ±2A, which gives 12 partial-product rows instead of 24. A negative digit is formed by inverting the selected multiple and adding a one at the row's lowest weight. Those injected ones share a single extra row with an unsigned correction term. The correction adds A shifted up by the operand width whenever the multiplier's top bit is set, because the recoding otherwise reads the multiplier as a signed number. The resulting 13 rows pass through layers of 3:2 carry-save compressors down to two rows. One carry-propagate adder then sums those two rows.

With the default configuration the product is registered. The register loads only on a cycle with `valid_in` high, and `valid_out` follows one cycle later. A parameter removes the register for a purely combinational path. The operand width parameter must be even.

Top module: `booth_wallace_mul`

## Requirements
- R1: One cycle after a cycle with `valid_in` high, `product` equals the unsigned product of the `op_a` and `op_b` values that were presented in that cycle.
- R2: `valid_out` is high in exactly the cycle after each cycle in which `valid_in` is high, and low in every other cycle.
- R3: After a cycle with `valid_in` low, `product` keeps its previous value, even if the operands changed.
- R4: While reset (`rst_n` low) is applied and right after it, `valid_out` is 0 and `product` is 0.
- R5: A multiplier `op_b` with bit 23 set (values of 2^23 or more) still gives the exact unsigned product.
- R6: If either operand is zero, the product is zero.
- R7: Full-scale operands 0xFFFFFF × 0xFFFFFF give 0xFFFFFE000001.
- R8: Multiplier patterns whose triples {b[2i+1], b[2i], b[2i−1]} (with b[−1] = 0) select every digit value 0, +A, +2A, −A and −2A give exact products. Examples are 0xAAAAAA, 0x555555, 0xCCCCCC, 0x333333 and 0x924924.
- R9: With `valid_in` held high on consecutive cycles, a new product appears every cycle, in the order the operands were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operands valid this cycle |
| op_a | input | 24 | Multiplicand, unsigned |
| op_b | input | 24 | Multiplier, unsigned, Booth-recoded |
| valid_out | output | 1 | Product valid |
| product | output | 48 | Unsigned 48-bit product |

## Verification
The operands are swept over every pair drawn from zero, one, full scale, 2^23 and 2^23+1. Zero separates the always-zero digits from faulty sign handling. Full scale and the 2^23 values expose a missing or misplaced unsigned correction row, and one isolates the plain +A row placement. Alternating and periodic multiplier patterns force every Booth digit value, so a wrong entry in the recoding map or a dropped negation one shows up. Random pairs, a hold test with changing operands and a back-to-back stream then separate datapath faults from load-enable and valid-timing faults.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef struct packed {
    logic loadEn;
  } ctrlStrobes_t;

  // rows left after one layer of 3:2 compression
  function automatic int rowsAfter(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // rows present at the input of layer l
  function automatic int rowsAt(input int n, input int l);
    int c;
    c = n;
    for (int k = 0; k < l; k++) c = rowsAfter(c);
    return c;
  endfunction

  // layers needed to reach two rows
  function automatic int layerCount(input int n);
    int c;
    int k;
    c = n;
    k = 0;
    while (c > 2) begin
      c = rowsAfter(c);
      k++;
    end
    return k;
  endfunction

endpackage

// File: rtl/booth_mul_csa.sv
module booth_mul_csa #(
  parameter int W = 48
) (
  input  logic [W-1:0] inX,
  input  logic [W-1:0] inY,
  input  logic [W-1:0] inZ,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carryOut
);
  logic [W-1:0] maj;

  assign sumOut   = inX ^ inY ^ inZ;
  assign maj      = (inX & inY) | (inX & inZ) | (inY & inZ);
  assign carryOut = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/booth_mul_ctrl.sv
module booth_mul_ctrl
  import booth_mul_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         validIn,
  output ctrlStrobes_t strb,
  output logic         validOut
);
  assign strb.loadEn = validIn;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) validOut <= 1'b0;
        else        validOut <= validIn;
      end
    end else begin : g_comb
      assign validOut = validIn;
    end
  endgenerate
endmodule

// File: rtl/booth_mul_dp.sv
module booth_mul_dp
  import booth_mul_pkg::*;
#(
  parameter int WIDTH   = 24,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       strb,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] prodOut
);
  localparam int PW    = 2 * WIDTH;
  localparam int NDIG  = WIDTH / 2;
  localparam int NROWS = NDIG + 1;
  localparam int NLAY  = layerCount(NROWS);

  logic [PW-1:0]   tree [0:NLAY][0:NROWS-1];
  logic [WIDTH:0]  bExt;
  logic [NDIG-1:0] negDig;
  logic [PW-1:0]   corrRow;
  logic [PW-1:0]   sumRow;

  assign bExt = {opB, 1'b0};

  // Booth recoding: one row per digit
  generate
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
      logic [2:0]     trip;
      logic           selOne;
      logic           selTwo;
      logic           isNeg;
      logic [WIDTH:0] mult;
      logic [PW-1:0]  ext;

      assign trip = bExt[2*i+2 -: 3];

      always_comb begin
        selOne = 1'b0;
        selTwo = 1'b0;
        isNeg  = 1'b0;
        case (trip)
          3'b001, 3'b010: selOne = 1'b1;
          3'b011:         selTwo = 1'b1;
          3'b100:         begin selTwo = 1'b1; isNeg = 1'b1; end
          3'b101, 3'b110: begin selOne = 1'b1; isNeg = 1'b1; end
          default:        ;
        endcase
      end

      assign mult       = selTwo ? {opA, 1'b0} : (selOne ? {1'b0, opA} : '0);
      assign ext        = {{(PW-WIDTH-1){1'b0}}, mult};
      assign tree[0][i] = (isNeg ? ~ext : ext) << (2 * i);
      assign negDig[i]  = isNeg;
    end
  endgenerate

  // extra row: unsigned correction plus the negation ones
  always_comb begin
    corrRow = opB[WIDTH-1] ? ({{WIDTH{1'b0}}, opA} << WIDTH) : '0;
    for (int k = 0; k < NDIG; k++) corrRow[2*k] = negDig[k];
  end
  assign tree[0][NDIG] = corrRow;

  // layered 3:2 reduction
  generate
    for (genvar l = 0; l < NLAY; l++) begin : g_lay
      localparam int CUR = rowsAt(NROWS, l);
      localparam int GRP = CUR / 3;
      localparam int NXT = rowsAfter(CUR);
      for (genvar g = 0; g < GRP; g++) begin : g_csa
        booth_mul_csa #(.W(PW)) csa_i (
          .inX     (tree[l][3*g]),
          .inY     (tree[l][3*g+1]),
          .inZ     (tree[l][3*g+2]),
          .sumOut  (tree[l+1][2*g]),
          .carryOut(tree[l+1][2*g+1])
        );
      end
      for (genvar j = 2 * GRP; j < NROWS; j++) begin : g_pass
        if (j < NXT) begin : g_keep
          assign tree[l+1][j] = tree[l][j+GRP];
        end else begin : g_zero
          assign tree[l+1][j] = '0;
        end
      end
    end
  endgenerate

  assign sumRow = tree[NLAY][0] + tree[NLAY][1];

  generate
    if (REG_OUT) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           prodOut <= '0;
        else if (strb.loadEn) prodOut <= sumRow;
      end
    end else begin : g_out_comb
      assign prodOut = sumRow;
    end
  endgenerate
endmodule

// File: rtl/booth_wallace_mul.sv
module booth_wallace_mul
  import booth_mul_pkg::*;
#(
  parameter int WIDTH   = 24,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_in,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic               valid_out,
  output logic [2*WIDTH-1:0] product
);
  ctrlStrobes_t strb;

  booth_mul_ctrl #(.REG_OUT(REG_OUT)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .validIn (valid_in),
    .strb    (strb),
    .validOut(valid_out)
  );

  booth_mul_dp #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .opA    (op_a),
    .opB    (op_b),
    .prodOut(product)
  );
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int WIDTH   = 24,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               valid_in,
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic               valid_out,
  input logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  generate
    if (REG_OUT) begin : g_props
      // R1
      prod_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> product == (PW'($past(op_a)) * PW'($past(op_b))));
      // R2
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
      // R2
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
      // R3
      prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(product));
      // R6
      zero_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && (op_a == '0 || op_b == '0)) |=> product == '0);
    end
  endgenerate
endmodule

bind booth_wallace_mul booth_mul_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_in (valid_in),
  .op_a     (op_a),
  .op_b     (op_b),
  .valid_out(valid_out),
  .product  (product)
);

// File: tb/booth_wallace_mul_tb_top.sv
module booth_wallace_mul_tb_top;
  localparam int W  = 24;
  localparam int PW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          validIn = 1'b0;
  logic [W-1:0]  opA = '0;
  logic [W-1:0]  opB = '0;
  logic          validOut;
  logic [PW-1:0] prod;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  booth_wallace_mul #(.WIDTH(W), .REG_OUT(1'b1)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_in (validIn),
    .op_a     (opA),
    .op_b     (opB),
    .valid_out(validOut),
    .product  (prod)
  );

  function automatic logic [PW-1:0] refMul(input logic [W-1:0] a, input logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one pair, result sampled at the negedge after the loading edge
  task automatic mulOne(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    opA = a;
    opB = b;
    validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    check("R2", PW'(validOut), PW'(1'b1));
    check(req, prod, refMul(a, b));
  endtask

  logic [W-1:0] corners [5];
  logic [W-1:0] pats [8];

  initial begin
    corners[0] = 24'h000000; corners[1] = 24'h000001; corners[2] = 24'hFFFFFF;
    corners[3] = 24'h800000; corners[4] = 24'h800001;
    pats[0] = 24'hAAAAAA; pats[1] = 24'h555555; pats[2] = 24'hCCCCCC;
    pats[3] = 24'h333333; pats[4] = 24'h924924; pats[5] = 24'h6DB6DB;
    pats[6] = 24'hF0F0F0; pats[7] = 24'h0F0F0F;

    // R4: reset state
    repeat (3) @(negedge clk);
    check("R4", PW'(validOut), '0);
    check("R4", prod, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4", PW'(validOut), '0);
    check("R4", prod, '0);

    // corner sweep: R5, R6, R7
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        string tag;
        if (corners[i] == 0 || corners[j] == 0) tag = "R6";
        else if (corners[i] == 24'hFFFFFF && corners[j] == 24'hFFFFFF) tag = "R7";
        else if (corners[j][W-1]) tag = "R5";
        else tag = "R1";
        mulOne(tag, corners[i], corners[j]);
      end
    end
    mulOne("R7", 24'hFFFFFF, 24'hFFFFFF);
    check("R7", prod, 48'hFFFFFE000001);

    // R8: Booth digit patterns against several multiplicands
    for (int p = 0; p < 8; p++) begin
      mulOne("R8", 24'hFFFFFF, pats[p]);
      mulOne("R8", 24'h9E3779, pats[p]);
      mulOne("R8", pats[p], pats[7-p]);
    end

    // walking one in the multiplier: R5 at the top bit
    for (int k = 0; k < W; k++) mulOne(k == W - 1 ? "R5" : "R1", 24'hC5A3F1, 24'(1) << k);

    // R1: random pairs
    for (int n = 0; n < 400; n++) mulOne("R1", W'($urandom), W'($urandom));

    // R3: product holds while operands change without valid
    mulOne("R1", 24'h123456, 24'hABCDEF);
    for (int n = 0; n < 4; n++) begin
      opA = W'($urandom);
      opB = W'($urandom);
      @(negedge clk);
      check("R3", prod, refMul(24'h123456, 24'hABCDEF));
      check("R2", PW'(validOut), '0);
    end

    // R9: back-to-back stream
    begin
      logic [W-1:0] sa [16];
      logic [W-1:0] sb [16];
      for (int n = 0; n < 16; n++) begin
        sa[n] = W'($urandom);
        sb[n] = W'($urandom) | (n[0] ? 24'h800000 : 24'h0);
      end
      @(negedge clk);
      for (int n = 0; n < 16; n++) begin
        opA = sa[n];
        opB = sb[n];
        validIn = 1'b1;
        @(negedge clk);
        check("R9", prod, refMul(sa[n], sb[n]));
        check("R9", PW'(validOut), PW'(1'b1));
      end
      validIn = 1'b0;
      @(negedge clk);
      check("R2", PW'(validOut), '0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule